// File: doc/BRIEF.md
# CSR Field Legalization Unit

This block holds one read/write control register whose fields each follow their own legality convention, plus a small companion control register that governs some of them. The register-access side presents a write enable, a select bit choosing between the two registers, and write data. Both registers are read back continuously as legalized words. No write, legal or not, ever raises an error. An unsupported encoding is either dropped or resolved to a legal value by a fixed rule.

The main register carries four field classes. The selector field (bits [1:0]) accepts only its supported encodings and ignores the rest. The level field (bits [5:4]) accepts any write but only ever holds a legal value. Its legal set widens when the companion register's widen bit is set. A read-only constant sits in bits [7:6]. An alias field (bit 8) mirrors a flag in the companion register whenever the companion register makes it writable. All other bits are reserved and read as zero. Flipping the widen bit re-legalizes the level field at once. That change is not a write to the main register.

The level field is a small state machine with states LVL_ZERO, LVL_ONE and LVL_TWO. It has three transitions. T_HOLD keeps the state on no write or an unsupported write. T_LOAD moves to the state named by a supported write. T_RELEGAL forces LVL_ZERO when the widen bit changes.

Top module: `csr_legal_unit`

## Requirements
- R1: Reserved bits read as zero and ignore writes. In the main register these are all bits except [1:0], [5:4], [7:6] and 8. In the companion register they are all bits except [2:0].
- R2: Main bits [7:6] always read the parameter RO_VAL (default 2'b10), whatever is written to them.
- R3: A main write whose bits [1:0] are 0 or 1 stores that value in the selector. A write of 2 or 3 leaves the selector unchanged and raises no error.
- R4: The selector keeps one state bit but always reads back as the full two-bit encoding, so bit 1 reads 0.
- R5: Level field bits [5:4] accept encodings 0 and 1 when companion bit 0 (widen) is 0. They accept 0, 1 and 2 when widen is 1. An unsupported value (3, or 2 while narrow) leaves the field unchanged.
- R6: A companion write that changes the widen bit sets the level field to 0 in the same cycle, even if the old value is still legal. A companion write that keeps widen leaves the level field unchanged.
- R7: When companion bit 1 (alias enable) is 0, main bit 8 reads 0 and a main write does not affect companion bit 2. When alias enable is 1, main bit 8 reads companion bit 2 at once, including the cycle the enable takes effect. A main write then copies its bit 8 into companion bit 2.
- R8: A companion write stores its bits [2:0] as widen, alias enable and flag.
- R9: After reset the main register reads RO_VAL in [7:6] and zero elsewhere, and the companion register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_ctl | input | 1 | 1 selects the companion register, 0 the main register |
| wr_data | input | XLEN | Write data |
| rd_main | output | XLEN | Legalized main register value |
| rd_ctl | output | XLEN | Companion register value |

## Verification
The hardest situation to reach is a re-legalization that changes a value that was still legal. The level field must hold 1 or 2, and then widen must flip in a separate companion write. An alias enable that rises while the flag is already set is just as hard. Directed sequences set these up explicitly. Random companion writes keep widen and alias enable toggling between random main writes, so these orders recur with varied field contents.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;
    // main register field positions
    localparam int SEL_LSB   = 0;
    localparam int LVL_LSB   = 4;
    localparam int RO_LSB    = 6;
    localparam int ALIAS_BIT = 8;
    // companion register bits
    localparam int WIDEN_BIT = 0;
    localparam int AEN_BIT   = 1;
    localparam int FLAG_BIT  = 2;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2
    } lvl_e;
endpackage

// File: rtl/wlrl_field.sv
module wlrl_field #(
    parameter int FW     = 2,
    parameter int NLEGAL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [FW-1:0] wr_val,
    output logic [FW-1:0] rd_val
);
    localparam int SW = (NLEGAL > 1) ? $clog2(NLEGAL) : 1;

    logic [SW-1:0] st_q;
    logic          legal;

    assign legal = int'(wr_val) < NLEGAL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (wr_en && legal) begin
            st_q <= wr_val[SW-1:0];
        end
    end

    always_comb begin
        rd_val = FW'(st_q);
    end

    p_wlrl_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> $stable(rd_val));
    p_wlrl_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_val) < NLEGAL);
endmodule

// File: rtl/warl_level.sv
module warl_level
    import csr_legal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    input  logic       wide,
    input  logic       relegal,
    output logic [1:0] rd_val
);
    lvl_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LVL_ZERO;
        end else begin
            cur_q <= nxt;
        end
    end

    // T_RELEGAL beats T_LOAD; T_HOLD otherwise
    always_comb begin
        nxt = cur_q;
        if (relegal) begin
            nxt = LVL_ZERO;
        end else if (wr_en) begin
            unique case (wr_val)
                2'd0:    nxt = LVL_ZERO;
                2'd1:    nxt = LVL_ONE;
                2'd2:    nxt = wide ? LVL_TWO : cur_q;
                default: nxt = cur_q;
            endcase
        end
    end

    always_comb begin
        rd_val = cur_q;
    end

    p_warl_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_val != 2'd3) && (wide || rd_val != 2'd2));
    p_relegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        relegal |=> (rd_val == 2'd0));
endmodule

// File: rtl/csr_legal_unit.sv
module csr_legal_unit
    import csr_legal_pkg::*;
#(
    parameter int         XLEN   = 32,
    parameter logic [1:0] RO_VAL = 2'b10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_ctl,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_main,
    output logic [XLEN-1:0] rd_ctl
);
    localparam logic [XLEN-1:0] MAIN_USED = XLEN'(9'h1F3);
    localparam logic [XLEN-1:0] CTL_USED  = XLEN'(3'h7);

    logic       main_wr, ctl_wr, relegal;
    logic       widen_q, aen_q, flag_q;
    logic [1:0] sel_val, lvl_val;

    assign main_wr = wr_en && !wr_ctl;
    assign ctl_wr  = wr_en &&  wr_ctl;
    assign relegal = ctl_wr && (wr_data[WIDEN_BIT] != widen_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widen_q <= 1'b0;
            aen_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else if (ctl_wr) begin
            widen_q <= wr_data[WIDEN_BIT];
            aen_q   <= wr_data[AEN_BIT];
            flag_q  <= wr_data[FLAG_BIT];
        end else if (main_wr && aen_q) begin
            flag_q  <= wr_data[ALIAS_BIT];
        end
    end

    wlrl_field #(.FW(2), .NLEGAL(2)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (main_wr),
        .wr_val (wr_data[SEL_LSB +: 2]),
        .rd_val (sel_val)
    );

    warl_level u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (main_wr),
        .wr_val  (wr_data[LVL_LSB +: 2]),
        .wide    (widen_q),
        .relegal (relegal),
        .rd_val  (lvl_val)
    );

    always_comb begin
        rd_main                  = '0;
        rd_main[SEL_LSB +: 2]    = sel_val;
        rd_main[LVL_LSB +: 2]    = lvl_val;
        rd_main[RO_LSB +: 2]     = RO_VAL;
        rd_main[ALIAS_BIT]       = aen_q & flag_q;
        rd_ctl                   = '0;
        rd_ctl[WIDEN_BIT]        = widen_q;
        rd_ctl[AEN_BIT]          = aen_q;
        rd_ctl[FLAG_BIT]         = flag_q;
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_main & ~MAIN_USED) == '0) && ((rd_ctl & ~CTL_USED) == '0));
    p_ro_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_main[RO_LSB +: 2] == RO_VAL);
    p_alias_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && aen_q) |=> (rd_ctl[FLAG_BIT] == $past(wr_data[ALIAS_BIT])));
    p_alias_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && !aen_q) |=> $stable(rd_ctl));
endmodule

// File: tb/tb_csr_legal_unit.sv
module tb_csr_legal_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_ctl = 1'b0;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] rd_main, rd_ctl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [1:0] m_sel, m_lvl;
    logic       m_widen, m_aen, m_flag;

    always #2.5 clk = ~clk;

    csr_legal_unit #(.XLEN(XLEN), .RO_VAL(2'b10)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .rd_main(rd_main), .rd_ctl(rd_ctl)
    );

    function automatic logic [XLEN-1:0] exp_main();
        logic [XLEN-1:0] v = '0;
        v[1:0] = m_sel;
        v[5:4] = m_lvl;
        v[7:6] = 2'b10;
        v[8]   = m_aen & m_flag;
        return v;
    endfunction

    function automatic logic [XLEN-1:0] exp_ctl();
        return XLEN'({m_flag, m_aen, m_widen});
    endfunction

    task automatic model_write(input logic sel, input logic [XLEN-1:0] d);
        if (sel) begin
            if (d[0] != m_widen) m_lvl = 2'd0;
            m_widen = d[0];
            m_aen   = d[1];
            m_flag  = d[2];
        end else begin
            if (d[1:0] < 2'd2) m_sel = d[1:0];
            if (d[5:4] < 2'd2 || (d[5:4] == 2'd2 && m_widen)) m_lvl = d[5:4];
            if (m_aen) m_flag = d[8];
        end
    endtask

    task automatic check(input string tag);
        n_run++;
        if (rd_main !== exp_main()) begin
            n_fail++;
            $display("FAIL %s main actual=%h expected=%h", tag, rd_main, exp_main());
        end
        n_run++;
        if (rd_ctl !== exp_ctl()) begin
            n_fail++;
            $display("FAIL %s ctl actual=%h expected=%h", tag, rd_ctl, exp_ctl());
        end
    endtask

    task automatic wr(input logic sel, input logic [XLEN-1:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_ctl = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(sel, d);
        check(tag);
    endtask

    initial begin
        m_sel = 0; m_lvl = 0; m_widen = 0; m_aen = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset");
        wr(1'b0, 32'hFFFF_FFFF, "R1 R3 R5 all-ones ignored");
        wr(1'b0, 32'h0000_00C1, "R4 R2 sel=1 full encoding");
        wr(1'b0, 32'h0000_0002, "R3 sel illegal 2 kept");
        wr(1'b0, 32'h0000_0023, "R5 lvl 2 while narrow kept");
        wr(1'b0, 32'h0000_0010, "R5 lvl 1 stored");
        wr(1'b1, 32'h0000_0001, "R6 widen flips lvl to 0");
        wr(1'b0, 32'h0000_0020, "R5 lvl 2 while wide");
        wr(1'b1, 32'h0000_0001, "R6 same widen keeps lvl");
        wr(1'b0, 32'h0000_0030, "R5 lvl 3 kept");
        wr(1'b1, 32'h0000_0000, "R6 narrowing clears lvl");
        wr(1'b0, 32'h0000_0010, "R5 lvl 1 again");
        wr(1'b1, 32'h0000_0004, "R8 flag only");
        wr(1'b0, 32'h0000_0000, "R7 alias off ignores bit 8");
        wr(1'b1, 32'h0000_0006, "R7 alias on shows flag");
        wr(1'b0, 32'h0000_0000, "R7 alias write clears flag");
        wr(1'b0, 32'h0000_0100, "R7 alias write sets flag");
        wr(1'b1, 32'hFFFF_FFF8, "R1 R8 ctl reserved ignored");
        wr(1'b1, 32'h0000_0007, "R8 all ctl bits");
        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            logic            s = ($urandom % 4) == 0;
            logic [XLEN-1:0] d = $urandom;
            if ($urandom % 3 == 0) d = d & 32'h0000_0133;
            wr(s, d, "R1 R3 R5 R6 R7 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule